// File: doc/BRIEF.md
# Reloadable Up/Down Timer with Event Capture

A 16-bit general-purpose timer that counts one step per selected timer tick, up or down. In periodic mode it reloads a programmed value at each terminal count. In free-running mode it wraps around. Each terminal-count tick raises a sticky timeout flag. A rising edge on one of 32 event inputs can copy the running count into a capture register and raise a sticky capture flag.

Software reaches the block through a small word-addressed register port with combinational read data. The timer clock sources are modelled as single-cycle enable strobes: the bus clock (every cycle), a fast strobe and a slow strobe. The count readback normally passes through a two-stage synchronizer. Software can bypass it when the timer and the bus share one clock.

Top module: `updown_timer`

## Requirements
- R1: After reset, addresses 0, 1, 3 and 4 read 0x0000 and address 2 (control) reads 0x000A.
- R2: Control bits [6:5] pick the tick source: 00 gives a tick every cycle, 01 gives a tick on each cycle with `hf_tick_i` high, 10 gives a tick on each cycle with `lf_tick_i` high, and 11 gives no ticks. No tick occurs while control bit 2 (enable) is 0.
- R3: Control bit 1 sets the direction. With 1 each tick adds one, and with 0 each tick subtracts one.
- R4: With control bit 3 = 1 (periodic), a tick at the terminal count (0x0000 counting down, 0xFFFF counting up) loads the counter with the load register (address 0).
- R5: With control bit 3 = 0 (free-running), a terminal-count tick wraps the counter to 0xFFFF when counting down and to 0x0000 when counting up.
- R6: A terminal-count tick sets status bit 0 (address 4). The bit stays set until a write to address 5 with data bit 0 = 1. If the set and the clear fall in the same cycle, the set wins.
- R7: A load write in the same cycle as a timeout does not affect that reload, which uses the previous value. The new value appears in the load register one cycle later, once no timeout is in progress.
- R8: When control bits 7 and 3 are both 1, a write to address 5 with data bit 0 = 1 reloads the counter from the load register. This reload takes priority over a tick in the same cycle, and that tick then raises no timeout. When control bit 7 is 0, such a write leaves the counter unchanged.
- R9: When control bit 13 = 1, a rising edge on the event input chosen by control bits [12:8] copies the count held before that edge's update into the capture register (address 3). It also sets status bit 1. When control bit 13 = 0, events have no effect.
- R10: Status bit 1 clears on a write to address 5 with data bit 1 = 1. A capture in the same cycle wins over the clear.
- R11: Reading address 1 returns the count from two cycles earlier. When control bit 15 = 1, it returns the live count.
- R12: Control bits 15, 13:5 and 3:1 are writable and the other bits read 0. Writes to addresses 1, 3 and 4 are ignored. Address 5 is write-only and reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| hf_tick_i | input | 1 | Fast timer clock strobe |
| lf_tick_i | input | 1 | Slow timer clock strobe |
| evt_i | input | 32 | Event inputs for capture |

## Verification
Two pairs of events can land on the same edge: a terminal-count tick with a write that clears the timeout flag, and a selected event edge with a write that clears the capture flag. Directed steps line up a slow strobe or an event edge with the clear write in one cycle, and expect the flag to read back set. The random phase then mixes clears, load writes and ticks freely. Every read is compared with a bench reference model, which also catches a load write that lands on a timeout.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DW = 16;

  localparam logic [2:0] ADR_LOAD  = 3'd0;
  localparam logic [2:0] ADR_COUNT = 3'd1;
  localparam logic [2:0] ADR_CTRL  = 3'd2;
  localparam logic [2:0] ADR_CAPT  = 3'd3;
  localparam logic [2:0] ADR_STAT  = 3'd4;
  localparam logic [2:0] ADR_CLR   = 3'd5;

  localparam logic [DW-1:0] CTRL_RST   = 16'h000A;
  localparam logic [DW-1:0] CTRL_WMASK = 16'hBFEE;

  typedef struct packed {
    logic       byp;
    logic       rsv14;
    logic       evt_en;
    logic [4:0] evt_sel;
    logic       rld_clr;
    logic [1:0] clk_sel;
    logic       rsv4;
    logic       periodic;
    logic       en;
    logic       up;
    logic       rsv0;
  } ctrl_t;
endpackage

// File: rtl/timer_tick_sel.sv
module timer_tick_sel (
  input  logic       en_i,
  input  logic [1:0] clk_sel_i,
  input  logic       hf_tick_i,
  input  logic       lf_tick_i,
  output logic       tick_o
);
  always_comb begin
    unique case (clk_sel_i)
      2'b00:   tick_o = en_i;
      2'b01:   tick_o = en_i & hf_tick_i;
      2'b10:   tick_o = en_i & lf_tick_i;
      default: tick_o = 1'b0;  // reserved source: no ticks
    endcase
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          up_i,
  input  logic          periodic_i,
  input  logic          clr_rst_i,
  input  logic          load_we_i,
  input  logic [DW-1:0] load_wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] load_o,
  output logic          tmo_o
);
  logic [DW-1:0] cnt_q, load_q, pend_q;
  logic          pend_v_q;
  logic          at_term;

  assign at_term = up_i ? (&cnt_q) : ~(|cnt_q);
  assign tmo_o   = tick_i & at_term & ~clr_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_rst_i) begin
      cnt_q <= load_q;
    end else if (tick_i) begin
      if (at_term)       cnt_q <= periodic_i ? load_q : (up_i ? '0 : '1);
      else if (up_i)     cnt_q <= cnt_q + 1'b1;
      else               cnt_q <= cnt_q - 1'b1;
    end
  end

  // load writes landing on a timeout are parked until the timeout has passed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q   <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (load_we_i && !tmo_o) begin
      load_q   <= load_wdata_i;
      pend_v_q <= 1'b0;
    end else if (load_we_i) begin
      pend_q   <= load_wdata_i;
      pend_v_q <= 1'b1;
    end else if (pend_v_q && !tmo_o) begin
      load_q   <= pend_q;
      pend_v_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;
endmodule

// File: rtl/timer_capture.sv
module timer_capture #(
  parameter int DW    = 16,
  parameter int N_EVT = 32,
  localparam int SEL_W = $clog2(N_EVT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DW-1:0]    cnt_i,
  output logic [DW-1:0]    cap_o,
  output logic             hit_o
);
  logic [N_EVT-1:0] evt_q, evt_rise;
  logic [DW-1:0]    cap_q;

  assign evt_rise = evt_i & ~evt_q;
  assign hit_o    = en_i & evt_rise[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      cap_q <= '0;
    end else begin
      evt_q <= evt_i;
      if (hit_o) cap_q <= cnt_i;
    end
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/timer_sync.sv
module timer_sync #(
  parameter int DW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byp_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_none
      assign q_o = d_i;
      logic unused_ok;
      assign unused_ok = &{1'b0, clk_i, rst_ni, byp_i};
    end else begin : g_chain
      logic [DW-1:0] stg_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
          stg_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
      end
      assign q_o = byp_i ? d_i : stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/updown_timer.sv
module updown_timer
  import timer_pkg::*;
#(
  parameter int N_EVT       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = $clog2(N_EVT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             hf_tick_i,
  input  logic             lf_tick_i,
  input  logic [N_EVT-1:0] evt_i
);
  ctrl_t         ctrl_q;
  logic          tmo_flag_q, cap_flag_q;
  logic          tick, tmo, cap_hit, clr_wr, clr_rst;
  logic [DW-1:0] cnt, load_val, cap_val, cnt_rd;

  assign clr_wr  = we_i && (addr_i == ADR_CLR);
  assign clr_rst = clr_wr && wdata_i[0] && ctrl_q.rld_clr && ctrl_q.periodic;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= ctrl_t'(CTRL_RST);
      tmo_flag_q <= 1'b0;
      cap_flag_q <= 1'b0;
    end else begin
      if (we_i && addr_i == ADR_CTRL) ctrl_q <= ctrl_t'(wdata_i & CTRL_WMASK);
      if (tmo)                            tmo_flag_q <= 1'b1;
      else if (clr_wr && wdata_i[0])      tmo_flag_q <= 1'b0;
      if (cap_hit)                        cap_flag_q <= 1'b1;
      else if (clr_wr && wdata_i[1])      cap_flag_q <= 1'b0;
    end
  end

  timer_tick_sel u_tick (
    .en_i      (ctrl_q.en),
    .clk_sel_i (ctrl_q.clk_sel),
    .hf_tick_i (hf_tick_i),
    .lf_tick_i (lf_tick_i),
    .tick_o    (tick)
  );

  timer_counter #(.DW(DW)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .up_i         (ctrl_q.up),
    .periodic_i   (ctrl_q.periodic),
    .clr_rst_i    (clr_rst),
    .load_we_i    (we_i && addr_i == ADR_LOAD),
    .load_wdata_i (wdata_i),
    .cnt_o        (cnt),
    .load_o       (load_val),
    .tmo_o        (tmo)
  );

  timer_capture #(.DW(DW), .N_EVT(N_EVT)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .en_i   (ctrl_q.evt_en),
    .sel_i  (ctrl_q.evt_sel[SEL_W-1:0]),
    .cnt_i  (cnt),
    .cap_o  (cap_val),
    .hit_o  (cap_hit)
  );

  timer_sync #(.DW(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .byp_i  (ctrl_q.byp),
    .d_i    (cnt),
    .q_o    (cnt_rd)
  );

  always_comb begin
    unique case (addr_i)
      ADR_LOAD:  rdata_o = load_val;
      ADR_COUNT: rdata_o = cnt_rd;
      ADR_CTRL:  rdata_o = ctrl_q;
      ADR_CAPT:  rdata_o = cap_val;
      ADR_STAT:  rdata_o = {{(DW-2){1'b0}}, cap_flag_q, tmo_flag_q};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/updown_timer_chk.sv
module updown_timer_chk
  import timer_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [2:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input ctrl_t         ctrl_q,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] load_val,
  input logic [DW-1:0] cap_val,
  input logic          tick,
  input logic          tmo,
  input logic          cap_hit,
  input logic          clr_rst,
  input logic          tmo_flag_q
);
  AST_RESERVED_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.clk_sel == 2'b11 && !clr_rst) |=> $stable(cnt)); // R2

  AST_PERIODIC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !clr_rst && ctrl_q.periodic && !ctrl_q.up && cnt == '0) |=> cnt == $past(load_val)); // R4

  AST_FREE_WRAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !clr_rst && !ctrl_q.periodic && ctrl_q.up && (&cnt)) |=> cnt == '0); // R5

  AST_TMO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_flag_q && !(we_i && addr_i == ADR_CLR && wdata_i[0])) |=> tmo_flag_q); // R6

  AST_LOAD_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo && we_i && addr_i == ADR_LOAD) |=> load_val == $past(load_val)); // R7

  AST_CLR_KEEPS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_CLR && !ctrl_q.rld_clr && !tick) |=> $stable(cnt)); // R8

  AST_CAPTURE_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hit |=> cap_val == $past(cnt)); // R9

  AST_SYNC_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.byp && addr_i == ADR_COUNT) |-> rdata_o == $past(cnt, 2)); // R11
endmodule

bind updown_timer updown_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .ctrl_q     (ctrl_q),
  .cnt        (cnt),
  .load_val   (load_val),
  .cap_val    (cap_val),
  .tick       (tick),
  .tmo        (tmo),
  .cap_hit    (cap_hit),
  .clr_rst    (clr_rst),
  .tmo_flag_q (tmo_flag_q)
);

// File: tb/updown_timer_tb.sv
module updown_timer_tb;
  localparam time CLK_P = 8ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        hf_tick_i = 1'b0;
  logic        lf_tick_i = 1'b0;
  logic [31:0] evt_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  updown_timer u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .hf_tick_i (hf_tick_i),
    .lf_tick_i (lf_tick_i),
    .evt_i     (evt_i)
  );

  // reference model, written from the requirements
  logic [15:0] m_load, m_pend, m_cnt, m_ctrl, m_cap, m_s1, m_s2;
  logic        m_pend_v, m_tf, m_cf;
  logic [31:0] m_evq;

  task automatic model_step();
    logic tick, clr_wr, clr_rst, term, tmo, hit;
    logic [15:0] n_cnt;
    logic [31:0] rise;
    case (m_ctrl[6:5])
      2'b00:   tick = m_ctrl[2];
      2'b01:   tick = m_ctrl[2] & hf_tick_i;
      2'b10:   tick = m_ctrl[2] & lf_tick_i;
      default: tick = 1'b0;
    endcase
    clr_wr  = we_i && addr_i == 3'd5;
    clr_rst = clr_wr && wdata_i[0] && m_ctrl[7] && m_ctrl[3];
    term    = m_ctrl[1] ? (m_cnt == 16'hFFFF) : (m_cnt == 16'h0000);
    tmo     = tick && term && !clr_rst;
    rise    = evt_i & ~m_evq;
    hit     = m_ctrl[13] && rise[m_ctrl[12:8]];
    n_cnt   = m_cnt;
    if (clr_rst) n_cnt = m_load;
    else if (tick) begin
      if (term) n_cnt = m_ctrl[3] ? m_load : (m_ctrl[1] ? 16'h0000 : 16'hFFFF);
      else n_cnt = m_ctrl[1] ? m_cnt + 16'd1 : m_cnt - 16'd1;
    end
    m_s2 = m_s1;
    m_s1 = m_cnt;
    if (hit) m_cap = m_cnt;
    m_cnt = n_cnt;
    if (we_i && addr_i == 3'd0 && !tmo) begin m_load = wdata_i; m_pend_v = 1'b0; end
    else if (we_i && addr_i == 3'd0) begin m_pend = wdata_i; m_pend_v = 1'b1; end
    else if (m_pend_v && !tmo) begin m_load = m_pend; m_pend_v = 1'b0; end
    if (tmo) m_tf = 1'b1; else if (clr_wr && wdata_i[0]) m_tf = 1'b0;
    if (hit) m_cf = 1'b1; else if (clr_wr && wdata_i[1]) m_cf = 1'b0;
    if (we_i && addr_i == 3'd2) m_ctrl = wdata_i & 16'hBFEE;
    m_evq = evt_i;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_load = '0; m_pend = '0; m_cnt = '0; m_ctrl = 16'h000A; m_cap = '0;
      m_s1 = '0; m_s2 = '0; m_pend_v = 1'b0; m_tf = 1'b0; m_cf = 1'b0; m_evq = '0;
    end else begin
      model_step();
    end
  end

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_load;
      3'd1: return m_ctrl[15] ? m_cnt : m_s2;
      3'd2: return m_ctrl;
      3'd3: return m_cap;
      3'd4: return {14'd0, m_cf, m_tf};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R7";
      3'd1: return "R11";
      3'd2: return "R12";
      3'd3: return "R9";
      3'd4: return "R6";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = a;
    #1 check(tag, rdata_o, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic pulse_hf(input int n);
    @(negedge clk_i);
    hf_tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    hf_tick_i = 1'b0;
  endtask

  task automatic pulse_lf(input int n);
    @(negedge clk_i);
    lf_tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    lf_tick_i = 1'b0;
  endtask

  task automatic evt_edge(input int idx);
    @(negedge clk_i);
    evt_i = 32'd1 << idx;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(3'd0, 16'h0000, "R1");
    rd(3'd1, 16'h0000, "R1");
    rd(3'd2, 16'h000A, "R1");
    rd(3'd3, 16'h0000, "R1");
    rd(3'd4, 16'h0000, "R1");

    // R4 periodic down on fast strobe, live readback
    wr(3'd0, 16'd5);
    wr(3'd2, 16'h802C);
    pulse_hf(1);
    rd(3'd1, 16'd5, "R4");
    rd(3'd4, 16'h0001, "R6");
    pulse_hf(3);
    rd(3'd1, 16'd2, "R3");

    // R2 source select
    wr(3'd2, 16'h806C);
    pulse_hf(3);
    rd(3'd1, 16'd2, "R2");
    wr(3'd2, 16'h804C);
    pulse_hf(2);
    rd(3'd1, 16'd2, "R2");
    pulse_lf(2);
    rd(3'd1, 16'd0, "R2");

    // R7 load write on a timeout cycle
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 3'd0; wdata_i = 16'd9; lf_tick_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; lf_tick_i = 1'b0;
    addr_i = 3'd0; #1 check("R7", rdata_o, 16'd5);
    addr_i = 3'd1; #1 check("R7", rdata_o, 16'd5);
    rd(3'd0, 16'd9, "R7");

    // R6 clear, R8 counter reload on clear
    wr(3'd5, 16'h0001);
    rd(3'd4, 16'h0000, "R6");
    rd(3'd1, 16'd5, "R8");
    wr(3'd2, 16'h80CC);
    pulse_lf(2);
    rd(3'd1, 16'd3, "R8");
    wr(3'd5, 16'h0001);
    rd(3'd1, 16'd9, "R8");

    // R6 set beats clear in the same cycle
    wr(3'd2, 16'h804C);
    pulse_lf(9);
    rd(3'd1, 16'd0, "R3");
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 3'd5; wdata_i = 16'h0001; lf_tick_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; lf_tick_i = 1'b0;
    rd(3'd4, 16'h0001, "R6");
    rd(3'd1, 16'd9, "R4");

    // R5 free-running wraps
    wr(3'd2, 16'h8024);
    pulse_hf(10);
    rd(3'd1, 16'hFFFF, "R5");
    wr(3'd2, 16'h8026);
    pulse_hf(1);
    rd(3'd1, 16'h0000, "R5");
    pulse_hf(2);
    rd(3'd1, 16'd2, "R3");

    // R11 two-cycle readback lag
    wr(3'd2, 16'h0026);
    rd(3'd1, 16'd2, "R11");
    @(negedge clk_i);
    hf_tick_i = 1'b1; addr_i = 3'd1;
    @(negedge clk_i);
    hf_tick_i = 1'b0;
    #1 check("R11", rdata_o, 16'd2);
    @(negedge clk_i); #1 check("R11", rdata_o, 16'd2);
    @(negedge clk_i); #1 check("R11", rdata_o, 16'd3);

    // R9 capture on selected event 7
    wr(3'd2, 16'hA726);
    rd(3'd1, 16'd3, "R11");
    evt_edge(3);
    rd(3'd3, 16'd0, "R9");
    evt_edge(7);
    rd(3'd3, 16'd3, "R9");
    rd(3'd4, 16'h0003, "R9");
    wr(3'd2, 16'h8726);
    pulse_hf(1);
    evt_edge(7);
    rd(3'd3, 16'd3, "R9");

    // R10 capture flag clear and set-wins
    wr(3'd5, 16'h0002);
    rd(3'd4, 16'h0001, "R10");
    wr(3'd2, 16'hA726);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 3'd5; wdata_i = 16'h0002; evt_i = 32'h80;
    @(negedge clk_i);
    we_i = 1'b0; evt_i = '0;
    rd(3'd4, 16'h0003, "R10");
    rd(3'd3, 16'd4, "R10");

    // R12 register map
    wr(3'd1, 16'h1234);
    rd(3'd1, 16'd4, "R12");
    wr(3'd3, 16'h5555);
    rd(3'd3, 16'd4, "R12");
    wr(3'd2, 16'hFFFF);
    rd(3'd2, 16'hBFEE, "R12");
    rd(3'd5, 16'h0000, "R12");
    wr(3'd2, 16'h0000);

    // random phase against the reference model
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] ra;
      int sel;
      @(negedge clk_i);
      we_i = 1'b0;
      ra = 3'($urandom_range(0, 5));
      addr_i = ra;
      #1 check(tag_of(ra), rdata_o, model_read(ra));
      sel = $urandom_range(0, 15);
      if (sel < 3) begin
        we_i = 1'b1;
        addr_i = (sel == 0) ? 3'd0 : (sel == 1) ? 3'd2 : 3'd5;
        wdata_i = 16'($urandom);
        if (sel == 0 && $urandom_range(0, 1) == 1) wdata_i = 16'($urandom_range(0, 15));
        if (sel == 1) wdata_i[2] = 1'b1;
      end else if (sel == 3) begin
        we_i = 1'b1;
        addr_i = 3'($urandom_range(1, 4));
        wdata_i = 16'($urandom);
      end
      hf_tick_i = ($urandom_range(0, 1) == 1);
      lf_tick_i = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0) evt_i = $urandom;
    end
    @(negedge clk_i);
    we_i = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule